// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is an external bus master for one chip-select area. It shares a set of external data pins between address and data: an access first places the address on the upper data lanes while a latch strobe pulses, then uses the same lanes to transfer the data while a read or write strobe is held. The lane count of 8 or 16 bits comes from a small mode register. That register also holds a multiplex enable and a count of wait cycles to insert automatically.

On the internal side, a requester raises a request with an address, a direction flag and write data. It holds the request until an acknowledge pulse returns, along with read data when the access was a read. The mode register is written through a simple write-enable port and can always be read back. At the start of each access the controller captures the width and wait count. A register write made while an access is running therefore affects only the next access.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00 and the bus is idle: chip select high, latch, read, write and acknowledge low, and no data lane enabled.
- R2: A write to the mode register stores bit 7 (multiplex enable), bits 4:3 (width code) and bits 2:0 (wait count). Bits 6:5 always read as 0.
- R3: An accepted request produces, in this order: exactly one cycle with the latch strobe high and chip select low, then the data phase with the read or write strobe high, then one acknowledge cycle with chip select high. The controller then returns to idle.
- R4: The data-phase strobe stays high for exactly 1 + W cycles, where W is the wait count (0 to 7) captured at acceptance.
- R5: With width code 00 (8-bit), the latch cycle drives address bits 7:0 on data lanes 31:24. Only those lanes are enabled.
- R6: With width code 01 (16-bit), the latch cycle drives address bits 15:0 on data lanes 31:16. Only those lanes are enabled.
- R7: Width codes 10 and 11 behave exactly like code 00.
- R8: During a write data phase, the low 8 or 16 bits of the write data are driven on the same lanes that carried the address, with the same lane enables.
- R9: During a read data phase no lane is enabled. The lanes are sampled on the last strobe cycle. The value is right-aligned and zero-extended to 16 bits, and it is valid while acknowledge is high.
- R10: A mode register write made during an access leaves that access's width and wait count unchanged. The new values apply from the next access.
- R11: The read and write strobes are never high together, and neither is high in the same cycle as the latch strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write enable |
| cfg_wdata_i | input | 8 | Mode register write value |
| cfg_rdata_o | output | 8 | Mode register read value |
| req_i | input | 1 | Access request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with acknowledge |
| bus_d_o | output | 32 | External data lanes, driven value |
| bus_d_i | input | 32 | External data lanes, sampled value |
| bus_oe_o | output | 32 | Per-bit output enable for the data lanes |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| cs_no | output | 1 | Chip select, active low |

## Verification
On every cycle, the assertions check the ordering rules between the strobes. They check that the latch strobe is followed by a data strobe, that the acknowledge is a single pulse after a strobe, and that no lane is driven while reading. They also check that the lanes below the top 16 are never enabled and that the register's unused bits stay at zero. Some behaviour only the bench scenarios can show. This covers the exact lane contents for each width code, including the reserved codes, and the strobe length for each wait count. It also covers read sampling on the last wait cycle against changing lane values, and the deferral of a register write made in the middle of an access.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_DONE} bus_state_e;
  localparam logic [7:0] MODE_MASK = 8'h9F;
  localparam logic [1:0] BW_WIDE   = 2'b01;
endpackage

// File: rtl/mux_bus_mode_reg.sv
module mux_bus_mode_reg
  import mux_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wide_o,
  output logic [2:0] wait_o
);
  logic [7:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else if (we_i) reg_q <= wdata_i & MODE_MASK;
  end

  assign rdata_o = reg_q;
  // reserved width codes fall back to narrow
  assign wide_o  = (reg_q[4:3] == BW_WIDE);
  assign wait_o  = reg_q[2:0];
endmodule

// File: rtl/mux_bus_lane_map.sv
module mux_bus_lane_map #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              wide_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] val_i,
  input  logic [WORD_W-1:0] bus_top_i,
  output logic [DATA_W-1:0] d_o,
  output logic [DATA_W-1:0] oe_o,
  output logic [WORD_W-1:0] rd_o
);
  localparam int NLANE = DATA_W / LANE_W;

  int unsigned        nbits;
  logic [WORD_W-1:0]  mask;
  logic [DATA_W-1:0]  drv;

  always_comb begin
    nbits = wide_i ? WORD_W : LANE_W;
    mask  = wide_i ? '1 : WORD_W'((1 << LANE_W) - 1);
    drv   = DATA_W'(val_i & mask) << (DATA_W - nbits);
    d_o   = en_i ? drv : '0;
    rd_o  = (bus_top_i >> (WORD_W - nbits)) & mask;
  end

  // lane k counts down from the top byte of the bus
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign oe_o[DATA_W-1-k*LANE_W -: LANE_W] =
      {LANE_W{en_i && (k < int'(nbits / LANE_W))}};
  end
endmodule

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
  import mux_bus_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wide_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [WORD_W-1:0] lane_rd_i,
  output logic              wide_o,
  output logic              drv_en_o,
  output logic [WORD_W-1:0] drv_val_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              cs_no,
  output logic              ack_o,
  output logic [WORD_W-1:0] rdata_o
);
  bus_state_e        st_q;
  logic [WAIT_W-1:0] cnt_q, wait_q;
  logic              we_q, wide_q;
  logic [WORD_W-1:0] addr_q, wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          // configuration is frozen here for the whole access
          st_q    <= ST_ADDR;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          wide_q  <= wide_i;
          wait_q  <= wait_i;
        end
        ST_ADDR: begin
          st_q  <= ST_DATA;
          cnt_q <= '0;
        end
        ST_DATA: begin
          if (cnt_q == wait_q) begin
            st_q <= ST_DONE;
            if (!we_q) rdata_q <= lane_rd_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ale_o     = (st_q == ST_ADDR);
  assign rd_o      = (st_q == ST_DATA) && !we_q;
  assign wr_o      = (st_q == ST_DATA) && we_q;
  assign cs_no     = !((st_q == ST_ADDR) || (st_q == ST_DATA));
  assign ack_o     = (st_q == ST_DONE);
  assign drv_en_o  = ale_o || wr_o;
  assign drv_val_o = ale_o ? addr_q : wdata_q;
  assign wide_o    = wide_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int LANE_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [DATA_W-1:0] bus_d_o,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_oe_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              cs_no
);
  logic              cfg_wide, act_wide, drv_en;
  logic [2:0]        cfg_wait;
  logic [WORD_W-1:0] drv_val, lane_rd;

  mux_bus_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .wide_o  (cfg_wide),
    .wait_o  (cfg_wait)
  );

  mux_bus_fsm #(.WORD_W(WORD_W), .WAIT_W(WAIT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wide_i    (cfg_wide),
    .wait_i    (WAIT_W'(cfg_wait)),
    .lane_rd_i (lane_rd),
    .wide_o    (act_wide),
    .drv_en_o  (drv_en),
    .drv_val_o (drv_val),
    .ale_o     (ale_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .cs_no     (cs_no),
    .ack_o     (ack_o),
    .rdata_o   (rdata_o)
  );

  mux_bus_lane_map #(.DATA_W(DATA_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_lanes (
    .wide_i    (act_wide),
    .en_i      (drv_en),
    .val_i     (drv_val),
    .bus_top_i (bus_d_i[DATA_W-1 -: WORD_W]),
    .d_o       (bus_d_o),
    .oe_o      (bus_oe_o),
    .rd_o      (lane_rd)
  );
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              cs_no,
  input logic              ack_o,
  input logic [DATA_W-1:0] bus_oe_o,
  input logic [7:0]        cfg_rdata_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !(ale_o || rd_o || wr_o));
  assert_pad_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[6:5] == 2'b00);
  assert_ale_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !cs_no);
  assert_ale_then_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (rd_o || wr_o));
  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_ack_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(rd_o || wr_o));
  assert_low_lanes_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o[DATA_W-WORD_W-1:0] == '0);
  assert_read_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (bus_oe_o == '0));
  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o) && !(ale_o && (rd_o || wr_o)));
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ale_o       (ale_o),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .cs_no       (cs_no),
  .ack_o       (ack_o),
  .bus_oe_o    (bus_oe_o),
  .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/mux_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_bus_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic        ack, ale, rd, wr, cs_n;
  logic [31:0] bus_do, bus_oe;
  logic [31:0] bus_di = '0;

  int total = 0;
  int bad = 0;
  logic [7:0] cfg_shadow = '0;

  always #2 clk = ~clk;

  mux_bus_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .bus_d_o(bus_do),
    .bus_d_i(bus_di), .bus_oe_o(bus_oe), .ale_o(ale), .rd_o(rd), .wr_o(wr),
    .cs_no(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lanes(input logic [15:0] v, input int nb);
    return (nb == 16) ? {v, 16'h0} : {v[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] exp_oe(input int nb);
    return (nb == 16) ? 32'hFFFF_0000 : 32'hFF00_0000;
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_shadow = v & 8'h9F;
    chk(cfg_rdata == cfg_shadow, "R2 readback", 32'(cfg_rdata), 32'(cfg_shadow));
  endtask

  task automatic access(input bit w_en, input logic [15:0] a, input logic [15:0] wd,
                        input bit midchg, input logic [7:0] newcfg);
    int          w, nb, ale_cnt, st_cnt;
    bit          done;
    string       tag;
    logic [15:0] good, exp_rd;
    w  = int'(cfg_shadow[2:0]);
    nb = (cfg_shadow[4:3] == 2'b01) ? 16 : 8;
    tag = (cfg_shadow[4:3] == 2'b01) ? "R6" : (cfg_shadow[4:3] == 2'b00) ? "R5" : "R7";
    good   = 16'($urandom);
    exp_rd = (nb == 16) ? good : {8'h00, good[7:0]};
    ale_cnt = 0; st_cnt = 0; done = 0;
    @(negedge clk);
    req = 1'b1; we = w_en; addr = a; wdata = wd;
    bus_di = 32'($urandom);
    for (int i = 0; i < 40 && !done; i++) begin
      @(negedge clk);
      if (cfg_we) cfg_we = 1'b0;
      chk(!(rd && wr) && !(ale && (rd || wr)), "R11 strobe overlap",
          {29'b0, ale, rd, wr}, 32'h0);
      if (ale) begin
        ale_cnt++;
        chk(cs_n == 1'b0, "R3 cs during latch", 32'(cs_n), 32'h0);
        chk(bus_do == exp_lanes(a, nb), {tag, " address lanes"}, bus_do, exp_lanes(a, nb));
        chk(bus_oe == exp_oe(nb), {tag, " address enables"}, bus_oe, exp_oe(nb));
        if (midchg) begin
          cfg_we = 1'b1; cfg_wdata = newcfg;
        end
      end
      if (rd || wr) begin
        st_cnt++;
        if (st_cnt == 1) begin
          chk(ale_cnt == 1, "R3 latch before strobe", 32'(ale_cnt), 32'h1);
          chk(wr == w_en && rd == !w_en, "R3 strobe direction", {30'b0, rd, wr},
              {30'b0, !w_en, w_en});
          if (w_en) begin
            chk(bus_do == exp_lanes(wd, nb), "R8 write lanes", bus_do, exp_lanes(wd, nb));
            chk(bus_oe == exp_oe(nb), "R8 write enables", bus_oe, exp_oe(nb));
          end else begin
            chk(bus_oe == 32'h0, "R9 read no drive", bus_oe, 32'h0);
          end
        end
        if (!w_en) begin
          // only the last strobe cycle carries the expected value
          if (st_cnt == w + 1)
            bus_di = exp_lanes(good, nb) | ((nb == 16) ? (32'($urandom) & 32'h0000_FFFF)
                                                       : (32'($urandom) & 32'h00FF_FFFF));
          else
            bus_di = ~exp_lanes(good, nb);
        end
      end
      if (ack) begin
        done = 1;
        req = 1'b0;
        chk(st_cnt == w + 1, midchg ? "R10 wait kept" : "R4 strobe length",
            32'(st_cnt), 32'(w + 1));
        chk(cs_n == 1'b1, "R3 cs released at ack", 32'(cs_n), 32'h1);
        if (!w_en)
          chk(rdata == exp_rd, midchg ? "R10 read width kept" : "R9 read data",
              32'(rdata), 32'(exp_rd));
      end
    end
    if (!done) begin
      chk(1'b0, "R3 no acknowledge", 32'h0, 32'h1);
      req = 1'b0;
    end
    if (midchg) begin
      cfg_shadow = newcfg & 8'h9F;
      chk(cfg_rdata == cfg_shadow, "R10 new value stored", 32'(cfg_rdata), 32'(cfg_shadow));
    end
    @(negedge clk);
    chk(ack == 1'b0 && cs_n == 1'b1, "R3 back to idle", {30'b0, ack, cs_n}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 register reset", 32'(cfg_rdata), 32'h0);
    chk(cs_n && !ale && !rd && !wr && !ack && bus_oe == 0, "R1 bus idle",
        {27'b0, cs_n, ale, rd, wr, ack}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    // reset config: 8-bit, zero wait
    access(1'b1, 16'hA55A, 16'h1234, 1'b0, 8'h0);
    access(1'b0, 16'h0F0F, 16'h0, 1'b0, 8'h0);
    write_cfg(8'hFF);
    write_cfg(8'h80);
    access(1'b0, 16'hBEEF, 16'h0, 1'b0, 8'h0);
    write_cfg(8'h8F);
    access(1'b1, 16'hC3A1, 16'h7E81, 1'b0, 8'h0);
    access(1'b0, 16'h1357, 16'h0, 1'b0, 8'h0);
    write_cfg(8'h92);
    access(1'b1, 16'hFFEE, 16'hDDCC, 1'b0, 8'h0);
    access(1'b0, 16'h4321, 16'h0, 1'b0, 8'h0);
    write_cfg(8'h9B);
    access(1'b1, 16'h6789, 16'hABCD, 1'b0, 8'h0);
    write_cfg(8'h81);
    access(1'b0, 16'h2468, 16'h0, 1'b1, 8'h8E);
    access(1'b0, 16'h8642, 16'h0, 1'b0, 8'h0);
    access(1'b1, 16'h1111, 16'h2222, 1'b1, 8'h07);
    access(1'b1, 16'h3333, 16'h4444, 1'b0, 8'h0);
    for (int n = 0; n < 48; n++) begin
      if (n % 4 == 0) write_cfg(8'($urandom));
      access(1'($urandom), 16'($urandom), 16'($urandom), (n % 7 == 3), 8'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule